// File: doc/BRIEF.md
# Four-Channel Pulse Width Modulator

This block produces four independent pulse-width-modulated waveforms. Each channel counts prescaled clock ticks through a programmable period and drives its output to an active level for the first part of the period and to the opposite level for the rest. Software controls it through a flat register space with single-cycle write and read strobes. Reads are combinational, so `rd_data` reflects `rd_addr` in the same cycle. A read of the event register takes effect at the clock edge that ends the read cycle.

Start and stop are done through separate set and clear registers, so one channel can be switched without a read-modify-write. While a channel runs, its duty and period registers cannot be written directly. A new value is loaded through a per-channel staging register and takes effect at the next period boundary, so no period is ever cut short or stretched by a change. Each channel raises a sticky end-of-period flag. Reading the flag register returns all flags and clears them.

Top module: `pwm_quad_ctrl`

## Requirements
- R1: Writing 0x004 sets the run bit of every channel n whose write-data bit n is 1. Writing 0x008 clears the run bit of every such channel. Zero data bits leave their channel unchanged. Reading 0x00C returns the run bits in bits 3:0 and zeros above them.
- R2: The register at 0x01C holds one flag per channel, in bit n for channel n. A flag is set by each end of period of its channel. A read returns the flags and clears all of them. An end of period in the same cycle as that read stays set for the next read.
- R3: Channel n's registers sit at 0x200 + 0x20*n: control at +0x00, duty at +0x04, period at +0x08 and staging at +0x10. Duty, period and staging keep and read back only write-data bits 15:0, with zeros above.
- R4: Control bits 3:0 hold the prescale exponent, and a running channel advances its counter once every 2^exponent clocks. A written exponent above 10 is stored and read back as 10. Control bits 9 and 10 read back as written, and all other control bits read as 0.
- R5: A running channel counts from 0 up to period-1 and then wraps, so one period lasts period*2^exponent clocks. A period value of 0 behaves as 1.
- R6: Control bit 9 is the active level. A running channel outputs the active level while its counter is below the duty value and the inverse level otherwise. A stopped channel outputs the inverse level and restarts its counter and prescaler from zero.
- R7: Direct writes to the duty or period register of a running channel are ignored. Writes to a stopped channel take effect at once.
- R8: Control bit 10 picks the target of the staging register: 0 means duty, 1 means period. On a running channel a staging write is held pending and is copied into its target at the next end of period. A second staging write before that boundary replaces the pending value. On a stopped channel a staging write goes to the target at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 12 | Byte address of the write |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe, one cycle per read |
| rd_addr | input | 12 | Byte address of the read |
| rd_data | output | 32 | Read data, combinational from rd_addr |
| pwm_out | output | 4 | One waveform per channel, bit n is channel n |

## Verification
The embedded assertions watch the following on every cycle:
- the set and clear effect of start and stop writes on the run bits;
- that event flags stay set until a read, and that a read keeps only the events of its own cycle;
- the spacing of prescaler ticks;
- the counter staying below the period;
- duty and period staying frozen on a running channel between boundaries;
- the pending flag dropping when its value is committed.

Only the bench scenarios show the waveform itself. The bench measures the active-level count over exactly one period for random exponents, periods, duties and polarities, including period 0 and duty at or above the period. It also checks that the last of two staging writes wins, that a period change through staging alters the measured waveform, and the exact number of flags seen during back-to-back flag reads.

// File: rtl/pwmq_pkg.sv
// pwmq_pkg: shared constants and types for the four-channel PWM controller.
// Assumes byte addresses with 32-bit registers on 4-byte boundaries.
package pwmq_pkg;
    localparam int PRES_W    = 4;
    localparam int PRES_MAX  = 10;
    localparam int OFS_START = 'h004;
    localparam int OFS_STOP  = 'h008;
    localparam int OFS_RUN   = 'h00C;
    localparam int OFS_EVT   = 'h01C;
    localparam int CH_BASE   = 'h200;
    localparam int CH_STRIDE = 'h20;
    localparam int SUB_CTRL  = 'h00;
    localparam int SUB_DUTY  = 'h04;
    localparam int SUB_PRD   = 'h08;
    localparam int SUB_STAGE = 'h10;
    localparam int BIT_LEVEL = 9;
    localparam int BIT_TGT   = 10;

    // Per-channel control fields
    typedef struct packed {
        logic              tgt_prd;  // staging target: 1 = period, 0 = duty
        logic              level;    // active output level
        logic [PRES_W-1:0] pres;     // prescale exponent
    } ctrl_t;
endpackage

// File: rtl/pwmq_prescaler.sv
// pwmq_prescaler: emits one tick every 2^pres clocks while run is high.
// Assumes pres <= DIV_W. The count restarts from zero whenever run is low.
// An exponent lowered mid-count ticks on the next cycle because the compare uses >=.
module pwmq_prescaler #(
    parameter int PRES_W = 4,
    parameter int DIV_W  = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PRES_W-1:0] pres,
    output logic              tick
);
    logic [DIV_W-1:0] pcnt;
    logic [DIV_W:0]   span;
    logic [DIV_W:0]   lim;

    // Terminal count for the selected exponent
    always_comb begin
        span = (DIV_W+1)'(1) << pres;
        lim  = span - (DIV_W+1)'(1);
        tick = run && ({1'b0, pcnt} >= lim);
    end

    // Prescale counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) pcnt <= '0;
        else if (tick)      pcnt <= '0;
        else                pcnt <= pcnt + DIV_W'(1);
    end

    // R4: with a nonzero, unchanged exponent two ticks are never adjacent
    assert_tick_spacing_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && pres != '0) |=> (!tick || pres != $past(pres)));
endmodule

// File: rtl/pwmq_chan.sv
// pwmq_chan: one PWM channel. It holds the control, duty, period and staging
// registers, the period counter and the waveform. Assumes the top module
// decodes write strobes, each of which lasts one cycle.
module pwmq_chan
    import pwmq_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DIV_W = PRES_MAX
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             wr_ctrl,
    input  logic             wr_duty,
    input  logic             wr_prd,
    input  logic             wr_stage,
    input  logic [CNT_W-1:0] wval,
    input  ctrl_t            wctrl,
    output ctrl_t            ctrl_q,
    output logic [CNT_W-1:0] duty_q,
    output logic [CNT_W-1:0] prd_q,
    output logic [CNT_W-1:0] stage_q,
    output logic             wave,
    output logic             eop
);
    logic             tick;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   nxt;
    logic             wrap;
    logic             pend;
    logic             pend_tgt;
    logic [PRES_W-1:0] pres_sat;

    pwmq_prescaler #(.PRES_W(PRES_W), .DIV_W(DIV_W)) u_pres (
        .clk(clk), .rst_n(rst_n), .run(run), .pres(ctrl_q.pres), .tick(tick)
    );

    // Period boundary detect and exponent saturation
    always_comb begin
        nxt      = {1'b0, cnt} + (CNT_W+1)'(1);
        wrap     = tick && (nxt >= {1'b0, prd_q});
        eop      = wrap;
        pres_sat = (wctrl.pres > PRES_W'(PRES_MAX)) ? PRES_W'(PRES_MAX) : wctrl.pres;
    end

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n)       ctrl_q <= '0;
        else if (wr_ctrl) ctrl_q <= '{tgt_prd: wctrl.tgt_prd, level: wctrl.level, pres: pres_sat};
    end

    // Period counter
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else if (wrap)      cnt <= '0;
        else if (tick)      cnt <= cnt + CNT_W'(1);
    end

    // Staging value, its target and its pending flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q  <= '0;
            pend     <= 1'b0;
            pend_tgt <= 1'b0;
        end else begin
            if (wr_stage) begin
                stage_q  <= wval;
                pend_tgt <= ctrl_q.tgt_prd;
            end
            pend <= run && (wr_stage || (pend && !wrap));
        end
    end

    // Duty register: direct when stopped, staged at the boundary when running
    always_ff @(posedge clk) begin
        if (!rst_n)                                  duty_q <= '0;
        else if (!run && wr_duty)                    duty_q <= wval;
        else if (!run && wr_stage && !ctrl_q.tgt_prd) duty_q <= wval;
        else if (run && wrap && pend && !pend_tgt)   duty_q <= stage_q;
    end

    // Period register: direct when stopped, staged at the boundary when running
    always_ff @(posedge clk) begin
        if (!rst_n)                                  prd_q <= '0;
        else if (!run && wr_prd)                     prd_q <= wval;
        else if (!run && wr_stage && ctrl_q.tgt_prd) prd_q <= wval;
        else if (run && wrap && pend && pend_tgt)    prd_q <= stage_q;
    end

    // Output level
    always_comb begin
        if (run && (cnt < duty_q)) wave = ctrl_q.level;
        else                       wave = ~ctrl_q.level;
    end

    // R5: the counter stays below a nonzero period
    assert_cnt_in_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (run && prd_q != '0) |-> (cnt < prd_q));
    // R7: a running channel changes duty and period only at a boundary
    assert_frozen_running_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !wrap) |=> ($stable(duty_q) && $stable(prd_q)));
    // R8: a committed staging value leaves nothing pending
    assert_pend_cleared_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap && !wr_stage) |=> !pend);
endmodule

// File: rtl/pwm_quad_ctrl.sv
// pwm_quad_ctrl: register decode, run bits, end-of-period flags and the
// per-channel instances. Assumes single-cycle strobes and reads that are
// combinational from rd_addr.
module pwm_quad_ctrl
    import pwmq_pkg::*;
#(
    parameter int NUM_CH = 4,
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic [NUM_CH-1:0] pwm_out
);
    localparam int IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
    localparam logic [ADDR_W-1:0] CH_LO = ADDR_W'(CH_BASE);
    localparam logic [ADDR_W-1:0] CH_HI = ADDR_W'(CH_BASE + NUM_CH*CH_STRIDE);

    logic [NUM_CH-1:0] run_q;
    logic [NUM_CH-1:0] evt_q;
    logic [NUM_CH-1:0] eop_v;
    logic              start_wr, stop_wr, evt_rd;
    logic              w_in_ch, r_in_ch;
    logic [ADDR_W-1:0] w_rel, r_rel;
    logic [IDX_W-1:0]  w_idx, r_idx;
    logic [4:0]        w_sub, r_sub;
    ctrl_t             wctrl;

    ctrl_t             ctrl_a  [NUM_CH];
    logic [CNT_W-1:0]  duty_a  [NUM_CH];
    logic [CNT_W-1:0]  prd_a   [NUM_CH];
    logic [CNT_W-1:0]  stage_a [NUM_CH];

    // Address decode for both ports
    always_comb begin
        start_wr = wr_en && (wr_addr == ADDR_W'(OFS_START));
        stop_wr  = wr_en && (wr_addr == ADDR_W'(OFS_STOP));
        evt_rd   = rd_en && (rd_addr == ADDR_W'(OFS_EVT));
        w_in_ch  = (wr_addr >= CH_LO) && (wr_addr < CH_HI);
        r_in_ch  = (rd_addr >= CH_LO) && (rd_addr < CH_HI);
        w_rel    = wr_addr - CH_LO;
        r_rel    = rd_addr - CH_LO;
        w_idx    = w_rel[5 +: IDX_W];
        r_idx    = r_rel[5 +: IDX_W];
        w_sub    = w_rel[4:0];
        r_sub    = r_rel[4:0];
        wctrl    = '{tgt_prd: wr_data[BIT_TGT], level: wr_data[BIT_LEVEL],
                     pres: wr_data[PRES_W-1:0]};
    end

    // Run bits: set and clear registers
    always_ff @(posedge clk) begin
        if (!rst_n)        run_q <= '0;
        else if (start_wr) run_q <= run_q | wr_data[NUM_CH-1:0];
        else if (stop_wr)  run_q <= run_q & ~wr_data[NUM_CH-1:0];
    end

    // End-of-period flags: a read clears, same-cycle events survive
    always_ff @(posedge clk) begin
        if (!rst_n) evt_q <= '0;
        else        evt_q <= (evt_rd ? '0 : evt_q) | eop_v;
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic sel;
        assign sel = wr_en && w_in_ch && (w_idx == IDX_W'(i));
        pwmq_chan #(.CNT_W(CNT_W), .DIV_W(PRES_MAX)) u_chan (
            .clk(clk), .rst_n(rst_n), .run(run_q[i]),
            .wr_ctrl (sel && (w_sub == 5'(SUB_CTRL))),
            .wr_duty (sel && (w_sub == 5'(SUB_DUTY))),
            .wr_prd  (sel && (w_sub == 5'(SUB_PRD))),
            .wr_stage(sel && (w_sub == 5'(SUB_STAGE))),
            .wval(wr_data[CNT_W-1:0]), .wctrl(wctrl),
            .ctrl_q(ctrl_a[i]), .duty_q(duty_a[i]), .prd_q(prd_a[i]),
            .stage_q(stage_a[i]), .wave(pwm_out[i]), .eop(eop_v[i])
        );
    end

    // Read data multiplexer
    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(OFS_RUN)) begin
            rd_data[NUM_CH-1:0] = run_q;
        end else if (rd_addr == ADDR_W'(OFS_EVT)) begin
            rd_data[NUM_CH-1:0] = evt_q;
        end else if (r_in_ch) begin
            case (r_sub)
                5'(SUB_CTRL): begin
                    rd_data[PRES_W-1:0] = ctrl_a[r_idx].pres;
                    rd_data[BIT_LEVEL]  = ctrl_a[r_idx].level;
                    rd_data[BIT_TGT]    = ctrl_a[r_idx].tgt_prd;
                end
                5'(SUB_DUTY):  rd_data[CNT_W-1:0] = duty_a[r_idx];
                5'(SUB_PRD):   rd_data[CNT_W-1:0] = prd_a[r_idx];
                5'(SUB_STAGE): rd_data[CNT_W-1:0] = stage_a[r_idx];
                default:       rd_data = '0;
            endcase
        end
    end

    // R1: a start write leaves every selected channel running
    assert_start_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> ((run_q & $past(wr_data[NUM_CH-1:0])) == $past(wr_data[NUM_CH-1:0])));
    // R1: a stop write clears only the selected channels
    assert_stop_clears_R1: assert property (@(posedge clk) disable iff (!rst_n)
        stop_wr |=> (run_q == ($past(run_q) & ~$past(wr_data[NUM_CH-1:0]))));
    // R2: a flag read keeps only the events of its own cycle
    assert_evt_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt_rd |=> (evt_q == $past(eop_v)));
    // R2: without a read, flags are sticky
    assert_evt_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !evt_rd |=> ((evt_q & $past(evt_q)) == $past(evt_q)));
endmodule

// File: tb/pwm_quad_ctrl_tb.sv
// pwm_quad_ctrl_tb_top: seeded random and directed bench for pwm_quad_ctrl.
module pwm_quad_ctrl_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [11:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  pwm_out;

    int n_vec = 0;
    int n_bad = 0;

    pwm_quad_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .pwm_out(pwm_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [11:0] ch_reg(input int ch, input int sub);
        return 12'(32'h200 + ch*32'h20 + sub);
    endfunction

    function automatic int eff_prd(input int p);
        return (p == 0) ? 1 : p;
    endfunction

    function automatic int exp_active(input int p, input int d, input int pres);
        int pe = eff_prd(p);
        return ((d < pe) ? d : pe) << pres;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        #1 d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic measure(input int ch, input int n, input logic lvl, output int act);
        act = 0;
        repeat (n) begin
            @(negedge clk);
            if (pwm_out[ch] == lvl) act++;
        end
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int act;
        int hits;
        int pr [NCH];
        int du [NCH];
        int ps [NCH];
        logic lv [NCH];
        void'($urandom(32'h5EED_0042));

        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // Reset state (R1, R2, R4, R6)
        rd(12'h00C, r); chk("R1 reset run bits", r, 32'h0);
        rd(12'h01C, r); chk("R2 reset flags", r, 32'h0);
        rd(ch_reg(2, 0), r); chk("R4 reset control", r, 32'h0);
        chk("R6 reset idle level", {28'h0, pwm_out}, 32'hF);

        // R1: set and clear only touch selected channels
        wr(12'h004, 32'h5); rd(12'h00C, r); chk("R1 start 0x5", r, 32'h5);
        wr(12'h004, 32'h0); rd(12'h00C, r); chk("R1 start zeros", r, 32'h5);
        wr(12'h008, 32'h1); rd(12'h00C, r); chk("R1 stop bit0", r, 32'h4);
        wr(12'h004, 32'hA); rd(12'h00C, r); chk("R1 start 0xA", r, 32'hE);
        wr(12'h004, 32'hF); rd(12'h00C, r); chk("R1 all running", r, 32'hF);
        wr(12'h008, 32'hF); rd(12'h00C, r); chk("R1 all stopped", r, 32'h0);

        // R3 and R4: field widths and exponent saturation
        wr(ch_reg(3, 4), 32'hABCD_1234); rd(ch_reg(3, 4), r); chk("R3 duty low bits", r, 32'h1234);
        wr(ch_reg(3, 8), 32'h0F0F_8001); rd(ch_reg(3, 8), r); chk("R3 period low bits", r, 32'h8001);
        wr(ch_reg(3, 0), 32'hFFFF_FFFF); rd(ch_reg(3, 0), r); chk("R4 control saturate", r, 32'h60A);
        wr(ch_reg(3, 0), 32'h0000_0207); rd(ch_reg(3, 0), r); chk("R4 control fields", r, 32'h207);

        // Random waveform rounds (R4, R5, R6)
        for (int round = 0; round < 12; round++) begin
            wr(12'h008, 32'hF);
            for (int c = 0; c < NCH; c++) begin
                ps[c] = int'($urandom_range(3, 0));
                pr[c] = int'($urandom_range(40, 0));
                du[c] = int'($urandom_range(pr[c] + 3, 0));
                lv[c] = 1'($urandom_range(1, 0));
                wr(ch_reg(c, 0), {21'h0, 1'b0, lv[c], 5'h0, 4'(ps[c])});
                wr(ch_reg(c, 8), 32'(pr[c]));
                wr(ch_reg(c, 4), 32'(du[c]));
            end
            for (int c = 0; c < NCH; c++)
                chk("R6 stopped idle level", {31'h0, pwm_out[c]}, {31'h0, ~lv[c]});
            rd(ch_reg(round % NCH, 4), r);
            chk("R3 duty readback", r, 32'(du[round % NCH]));
            wr(12'h004, 32'hF);
            repeat (3) @(negedge clk);
            for (int c = 0; c < NCH; c++) begin
                measure(c, eff_prd(pr[c]) << ps[c], lv[c], act);
                chk("R5 R6 active clocks per period", 32'(act), 32'(exp_active(pr[c], du[c], ps[c])));
            end
        end
        wr(12'h008, 32'hF);

        // R2: flags persist after a stop, the read clears them
        wr(ch_reg(0, 0), 32'h0); wr(ch_reg(0, 8), 32'd200); wr(ch_reg(0, 4), 32'd10);
        rd(12'h01C, r);
        wr(12'h004, 32'h1);
        repeat (250) @(negedge clk);
        wr(12'h008, 32'h1);
        rd(12'h01C, r); chk("R2 flag set by period end", r, 32'h1);
        rd(12'h01C, r); chk("R2 flag cleared by read", r, 32'h0);

        // R2: back-to-back reads of a period-4 channel see one flag per period
        wr(ch_reg(0, 8), 32'd4);
        wr(12'h004, 32'h1);
        repeat (10) @(negedge clk);
        hits = 0;
        @(negedge clk);
        rd_en = 1'b1; rd_addr = 12'h01C;
        for (int k = 0; k < 13; k++) begin
            @(negedge clk);
            if (k < 12 && rd_data[0]) hits++;
        end
        rd_en = 1'b0;
        chk("R2 same-cycle event kept", 32'(hits), 32'd3);
        wr(12'h008, 32'h1);
        rd(12'h01C, r);

        // R8 and R7: staging on a running channel
        wr(ch_reg(1, 0), 32'h0); wr(ch_reg(1, 8), 32'd200); wr(ch_reg(1, 4), 32'd50);
        wr(12'h004, 32'h2);
        wr(ch_reg(1, 16), 32'd70);
        wr(ch_reg(1, 16), 32'd20);
        rd(ch_reg(1, 4), r); chk("R8 duty held until boundary", r, 32'd50);
        repeat (210) @(negedge clk);
        rd(ch_reg(1, 4), r); chk("R8 last staging write wins", r, 32'd20);
        wr(ch_reg(1, 0), 32'h400);
        wr(ch_reg(1, 16), 32'd30);
        rd(ch_reg(1, 8), r); chk("R8 period held until boundary", r, 32'd200);
        repeat (200) @(negedge clk);
        rd(ch_reg(1, 8), r); chk("R8 period staged", r, 32'd30);
        measure(1, 30, 1'b0, act);
        chk("R8 R5 new period waveform", 32'(act), 32'd20);
        wr(ch_reg(1, 4), 32'd5);
        rd(ch_reg(1, 4), r); chk("R7 duty write ignored while running", r, 32'd20);
        wr(ch_reg(1, 8), 32'd99);
        rd(ch_reg(1, 8), r); chk("R7 period write ignored while running", r, 32'd30);
        measure(1, 30, 1'b0, act);
        chk("R7 waveform unchanged", 32'(act), 32'd20);

        // R6 and R8: a stopped channel idles and takes staging writes at once
        wr(12'h008, 32'h2);
        chk("R6 idle after stop", {31'h0, pwm_out[1]}, 32'h1);
        wr(ch_reg(1, 0), 32'h0);
        wr(ch_reg(1, 16), 32'd77);
        rd(ch_reg(1, 4), r); chk("R8 stopped staging to duty", r, 32'd77);
        wr(ch_reg(1, 0), 32'h400);
        wr(ch_reg(1, 16), 32'd9);
        rd(ch_reg(1, 8), r); chk("R8 stopped staging to period", r, 32'd9);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule